// File: doc/BRIEF.md
# Loop Housekeeping Recurrence Unit

This unit sits beside one processor of a systolic loop accelerator. For each iteration that processor starts, it supplies the iteration's loop coordinates, the global memory addresses it touches, its position inside the processor's cluster of virtual processors, and a set of control predicates. None of these is derived from the time and processor indices with multipliers. The host downloads the values for the first few iterations, a normal increment per value, and a wrap increment per value and clustered axis. After the seeded iterations, each value advances with a single adder per clock.

Cluster position is kept as an odometer with one equality comparator per clustered axis. An axis of extent one is left out of the parameterisation, so it gets no comparator. When an odometer stage wraps, every tracked value uses that stage's wrap increment in place of its normal one. Predicates that repeat with the cluster period are not computed at all. They are replayed from a host-loaded ring whose length is set to the cluster size. A `start` pulse rewinds the unit, and an `adv` pulse marks each new iteration start.

Top module: `loop_housekeeper`

## Requirements
- R1: After reset, `val_o`, `pos_o` and `pred_o` are all zero, and every configuration word reads as zero.
- R2: A clock edge with `start` high zeroes every cluster position and the ring pointer, restarts the seed sequence, and loads each value with its seed slot 0.
- R3: For the first SEED_N iterations after `start` (iteration index k < SEED_N), value v shows its seed slot k exactly, whatever its increments are.
- R4: From iteration SEED_N onward, when no cluster axis wraps in the transition, each value equals its previous output plus its normal increment (slot 0), modulo 2^W.
- R5: Cluster positions form an odometer. Axis 0 counts 0 up to extent0-1 and then returns to 0. Axis a>0 steps only on the edge where every lower axis sits at its last position, and it returns to 0 after extent(a)-1. `pos_o` carries axis a in bits [a*EW +: EW].
- R6: When the position before an advance has axes 0..a all at their last positions, the value uses wrap increment slot 1+a for the highest such a instead of the normal increment.
- R7: `pred_o` equals ring entry number p, where p is the ring pointer. p advances by one on each `adv`, and after entry length-1 it returns to 0, so entries at or above the programmed length never appear.
- R8: Without `start` or `adv`, values and positions hold their state.
- R9: When `start` and `adv` are high in the same cycle, `start` takes effect and `adv` is ignored.
- R10: Host writes use `cfg_addr`. Ring entry r is at 0x00+r, with data bits [NPRED-1:0]. The ring length is at 0x40, and the extent of axis a is at 0x41+a. Seed slot s of value v is at 0x80+8v+s, and increment slot j of value v is at 0x84+8v+j. A write touches only the word it addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Rewind to iteration 0 |
| adv | input | 1 | Start of the next iteration |
| cfg_we | input | 1 | Host write strobe |
| cfg_addr | input | 8 | Host write address (R10 map) |
| cfg_wdata | input | W | Host write data |
| val_o | output | NVAL*W | Tracked values; value v in bits [v*W +: W] |
| pos_o | output | NCLU*EW | Cluster position per axis |
| pred_o | output | NPRED | Periodic predicates from the ring |

## Verification
The run uses a 3-by-2 cluster, so both a single-axis wrap and a double wrap occur, and each falls on a different iteration. Each increment slot holds a distinct value, and the seeds do not lie on the increment progression. A wrong slot choice, a seed replaced by a sum, or a seed window of the wrong length therefore gives a different number. The ring holds a distinct pattern in every live entry and a poisoned entry just past the programmed length, which shows whether the wrap is early or late. Idle cycles, a restart in the middle of a run, and `start` together with `adv` cover the hold and priority rules.

// File: rtl/loop_housekeeper.sv
module loop_housekeeper #(
  parameter int W      = 32,
  parameter int NVAL   = 4,
  parameter int NCLU   = 2,
  parameter int SEED_N = 3,
  parameter int NPRED  = 4,
  parameter int RING_N = 32,
  parameter int EW     = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 adv,
  input  logic                 cfg_we,
  input  logic [7:0]           cfg_addr,
  input  logic [W-1:0]         cfg_wdata,
  output logic [NVAL*W-1:0]    val_o,
  output logic [NCLU*EW-1:0]   pos_o,
  output logic [NPRED-1:0]     pred_o
);
  localparam int NINC = NCLU + 1;
  localparam int SW   = $clog2(NINC);
  localparam int RPW  = $clog2(RING_N);
  localparam int CW   = $clog2(SEED_N + 1);

  logic [W-1:0]     seed [NVAL][SEED_N];
  logic [W-1:0]     inc  [NVAL][NINC];
  logic [W-1:0]     cur  [NVAL];
  logic [NPRED-1:0] ring [RING_N];
  logic [EW-1:0]    ext  [NCLU];
  logic [EW-1:0]    pos  [NCLU];
  logic [EW-1:0]    pos_n[NCLU];
  logic [RPW:0]     rlen;
  logic [RPW-1:0]   rptr;
  logic [CW-1:0]    cnt;
  logic [NCLU-1:0]  edge_hit, carry;
  logic [SW-1:0]    sel;

  wire       wr_val  = cfg_we && cfg_addr[7];
  wire       wr_ring = cfg_we && (cfg_addr[7:6] == 2'b00);
  wire       wr_ctl  = cfg_we && (cfg_addr[7:6] == 2'b01);
  wire [3:0] wv      = cfg_addr[6:3];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int v = 0; v < NVAL; v++) begin
        for (int s = 0; s < SEED_N; s++) seed[v][s] <= '0;
        for (int j = 0; j < NINC; j++) inc[v][j] <= '0;
      end
      for (int r = 0; r < RING_N; r++) ring[r] <= '0;
      for (int a = 0; a < NCLU; a++) ext[a] <= '0;
      rlen <= '0;
    end else begin
      for (int v = 0; v < NVAL; v++) begin
        for (int s = 0; s < SEED_N; s++)
          if (wr_val && wv == 4'(v) && !cfg_addr[2] && cfg_addr[1:0] == 2'(s))
            seed[v][s] <= cfg_wdata;
        for (int j = 0; j < NINC; j++)
          if (wr_val && wv == 4'(v) && cfg_addr[2] && cfg_addr[1:0] == 2'(j))
            inc[v][j] <= cfg_wdata;
      end
      for (int r = 0; r < RING_N; r++)
        if (wr_ring && cfg_addr[5:0] == 6'(r)) ring[r] <= cfg_wdata[NPRED-1:0];
      if (wr_ctl && cfg_addr[5:0] == 6'd0) rlen <= cfg_wdata[RPW:0];
      for (int a = 0; a < NCLU; a++)
        if (wr_ctl && cfg_addr[5:0] == 6'(a + 1)) ext[a] <= cfg_wdata[EW-1:0];
    end
  end

  for (genvar a = 0; a < NCLU; a++) begin : g_axis
    assign edge_hit[a] = (pos[a] == ext[a] - EW'(1));
    if (a == 0) begin : g_first
      assign carry[a] = edge_hit[a];
      assign pos_n[a] = edge_hit[a] ? '0 : pos[a] + EW'(1);
    end else begin : g_next
      assign carry[a] = carry[a-1] & edge_hit[a];
      assign pos_n[a] = !carry[a-1] ? pos[a] : (edge_hit[a] ? '0 : pos[a] + EW'(1));
    end
    assign pos_o[a*EW +: EW] = pos[a];
  end

  always_comb begin
    sel = '0;
    for (int a = 0; a < NCLU; a++)
      if (carry[a]) sel = SW'(a + 1);
  end

  wire [CW-1:0] nidx    = cnt + CW'(1);
  wire          in_seed = (nidx < CW'(SEED_N));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int v = 0; v < NVAL; v++) cur[v] <= '0;
      for (int a = 0; a < NCLU; a++) pos[a] <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else if (start) begin
      for (int v = 0; v < NVAL; v++) cur[v] <= seed[v][0];
      for (int a = 0; a < NCLU; a++) pos[a] <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else if (adv) begin
      for (int v = 0; v < NVAL; v++)
        cur[v] <= in_seed ? seed[v][nidx] : cur[v] + inc[v][sel];
      for (int a = 0; a < NCLU; a++) pos[a] <= pos_n[a];
      rptr <= ({1'b0, rptr} == rlen - 1'b1) ? '0 : rptr + RPW'(1);
      if (in_seed) cnt <= nidx;
    end
  end

  for (genvar v = 0; v < NVAL; v++) begin : g_val
    assign val_o[v*W +: W] = cur[v];
  end

  assign pred_o = ring[rptr];
endmodule

module loop_housekeeper_chk #(
  parameter int W    = 32,
  parameter int NVAL = 4,
  parameter int NCLU = 2,
  parameter int EW   = 8,
  parameter int RPW  = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic               start,
  input logic               adv,
  input logic [NVAL*W-1:0]  val_o,
  input logic [NCLU*EW-1:0] pos_o,
  input logic [RPW-1:0]     rptr,
  input logic [RPW:0]       rlen
);
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !adv) |=> ($stable(val_o) && $stable(pos_o) && $stable(rptr)));

  a_r2_start_rewind: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (pos_o == '0 && rptr == '0));

  a_r7_ptr_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !start && {1'b0, rptr} == rlen - 1'b1) |=> (rptr == '0));

  a_r7_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !start && {1'b0, rptr} != rlen - 1'b1) |=> (rptr == $past(rptr) + RPW'(1)));

  a_r5_axis0_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !start && pos_o[EW-1:0] != '0) |=> (pos_o[EW-1:0] != $past(pos_o[EW-1:0])));
endmodule

bind loop_housekeeper loop_housekeeper_chk #(
  .W(W), .NVAL(NVAL), .NCLU(NCLU), .EW(EW), .RPW(RPW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .adv(adv),
  .val_o(val_o), .pos_o(pos_o), .rptr(rptr), .rlen(rlen)
);

// File: tb/tb_loop_housekeeper.sv
module tb_loop_housekeeper;
  localparam int W = 32, NVAL = 4, NCLU = 2, NPRED = 4, EW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0, start = 1'b0, adv = 1'b0, cfg_we = 1'b0;
  logic [7:0] cfg_addr = '0;
  logic [W-1:0] cfg_wdata = '0;
  logic [NVAL*W-1:0] val_o;
  logic [NCLU*EW-1:0] pos_o;
  logic [NPRED-1:0] pred_o;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  loop_housekeeper dut (
    .clk(clk), .rst_n(rst_n), .start(start), .adv(adv), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .val_o(val_o), .pos_o(pos_o), .pred_o(pred_o)
  );

  // {val0, val1, pos axis0, pos axis1, pred}
  localparam logic [83:0] TBL [14] = '{
    {32'd100, 32'd7,  8'd0, 8'd0, 4'h1},
    {32'd150, 32'd7,  8'd1, 8'd0, 4'h2},
    {32'd200, 32'd7,  8'd2, 8'd0, 4'h4},
    {32'd210, 32'd12, 8'd0, 8'd1, 4'h8},
    {32'd211, 32'd11, 8'd1, 8'd1, 4'h3},
    {32'd212, 32'd10, 8'd2, 8'd1, 4'hC},
    {32'd312, 32'd10, 8'd0, 8'd0, 4'h1},
    {32'd313, 32'd9,  8'd1, 8'd0, 4'h2},
    {32'd314, 32'd8,  8'd2, 8'd0, 4'h4},
    {32'd324, 32'd13, 8'd0, 8'd1, 4'h8},
    {32'd325, 32'd12, 8'd1, 8'd1, 4'h3},
    {32'd326, 32'd11, 8'd2, 8'd1, 4'hC},
    {32'd426, 32'd11, 8'd0, 8'd0, 4'h1},
    {32'd427, 32'd10, 8'd1, 8'd0, 4'h2}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [W-1:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic pulse(input logic s, input logic a);
    @(negedge clk);
    start = s; adv = a;
    @(negedge clk);
    start = 1'b0; adv = 1'b0;
  endtask

  task automatic row(input int k, input string vreq);
    chk({vreq, " val0"}, 64'(val_o[31:0]), 64'(TBL[k][83:52]));
    chk({vreq, " val1"}, 64'(val_o[63:32]), 64'(TBL[k][51:20]));
    chk("R5 pos", 64'(pos_o), 64'({TBL[k][11:4], TBL[k][19:12]}));
    chk("R7 pred", 64'(pred_o), 64'(TBL[k][3:0]));
  endtask

  function automatic string vreq_of(input int k);
    if (k < 3) return "R3";
    if (k % 3 == 0) return "R6";
    return "R4";
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 val", 64'(val_o[63:0]), 64'd0);
    chk("R1 pos/pred", 64'({pos_o, pred_o}), 64'd0);

    // R10 host map
    wr(8'h41, 3); wr(8'h42, 2); wr(8'h40, 6);
    wr(8'h00, 1); wr(8'h01, 2); wr(8'h02, 4); wr(8'h03, 8);
    wr(8'h04, 3); wr(8'h05, 12); wr(8'h06, 15);
    wr(8'h80, 100); wr(8'h81, 150); wr(8'h82, 200);
    wr(8'h84, 1); wr(8'h85, 10); wr(8'h86, 100);
    wr(8'h88, 7); wr(8'h89, 7); wr(8'h8A, 7);
    wr(8'h8C, 32'hFFFF_FFFF); wr(8'h8D, 5); wr(8'h8E, 0);
    chk("R2 no start yet", 64'(val_o[31:0]), 64'd0);

    pulse(1'b1, 1'b0);
    row(0, "R2");
    for (int k = 1; k < 14; k++) begin
      pulse(1'b0, 1'b1);
      row(k, vreq_of(k));
    end
    chk("R10 value2 untouched", 64'(val_o[95:64]), 64'd0);
    chk("R10 value3 untouched", 64'(val_o[127:96]), 64'd0);

    repeat (4) @(negedge clk);
    row(13, "R8");

    pulse(1'b1, 1'b1);
    row(0, "R9");

    pulse(1'b0, 1'b1);
    pulse(1'b0, 1'b1);
    row(2, "R3");
    pulse(1'b1, 1'b0);
    row(0, "R2");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule